// File: doc/BRIEF.md
# Relocatable Two-Bank CMOS Index/Data Port Decoder

This block sits between a host I/O bus and two 128-byte banks of battery-backed storage. Each bank has a pair of ports: an index port at an even base address and a data port one byte above it. Configuration registers hold each bank's base and its own enable bit. The host first writes a location into the index port. Later reads and writes of the data port then reach that location. The index stays in place until the host writes it again.

In bank 0, the lowest locations are not stored in the block. They pass to an external clock-register interface as a select, read and write strobes, and data in each direction. The rest of bank 0 and all of bank 1 are held in local storage. The host can read back the last byte written to the bank 0 index port. Each bank is split into 32-byte ranges, and each range has a lock bit. Once set, a lock bit stays set until reset. While a range is locked, data port reads return all ones and data port writes are dropped.

Top module: `cmos_banked_port`

## Requirements
- R1: After reset, the enable bits are 0, the bank 0 base reads back 0x70, the bank 1 base reads back 0x74, all lock bits are 0, and no I/O cycle is claimed.
- R2: Configuration select 0 holds the enable bits: bit 0 enables bank 0 and bit 1 enables bank 1. A disabled bank does not assert io_hit_o, returns 0xFF on reads and does not latch index writes.
- R3: A bank claims a cycle when io_addr_i[11:1] equals its base. io_addr_i[0]=0 selects the index port and 1 selects the data port. io_addr_i[15:12] is ignored.
- R4: Configuration selects 1/3 (high byte, A11..A8) and 2/4 (low byte, A7..A1) set the bank 0 / bank 1 base. The high byte reads back with bits 7:4 as zero and the low byte reads back with bit 0 as zero.
- R5: A write to an index port latches io_wdata_i[6:0] as that bank's location. Data port accesses use this location, and it persists until the index port is written again.
- R6: A read of the bank 0 index port returns the full last byte written to it. A read of the bank 1 index port returns 0xFF but still claims the cycle.
- R7: Bank 0 locations 0..14 are served by the clock interface. A data write asserts clk_reg_wr_o with clk_reg_sel_o equal to the location and clk_reg_wdata_o equal to the data. A data read asserts clk_reg_rd_o and returns clk_reg_rdata_i. Locations 15 and up are local storage.
- R8: The two banks keep separate storage and separate index registers.
- R9: A write to configuration select 5 ORs its data into the lock bits. Bits 3:0 cover bank 0 and bits 7:4 cover bank 1, with the bit within each half given by location[6:5]. Only reset clears them. In a locked range, data reads return 0xFF and data writes, including clock writes, are dropped.
- R10: When both banks decode the same address, bank 0 serves the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 3 | Configuration register select (0 enable, 1..4 bases, 5 lock) |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read-back of the selected configuration register |
| io_addr_i | input | 16 | Host I/O address |
| io_rd_i | input | 1 | Host I/O read strobe |
| io_wr_i | input | 1 | Host I/O write strobe |
| io_wdata_i | input | 8 | Host I/O write data |
| io_rdata_o | output | 8 | Host I/O read data, valid in the same cycle as io_rd_i |
| io_hit_o | output | 1 | The block claims the current I/O cycle |
| clk_reg_sel_o | output | 4 | Clock register select |
| clk_reg_rd_o | output | 1 | Clock register read strobe |
| clk_reg_wr_o | output | 1 | Clock register write strobe |
| clk_reg_wdata_o | output | 8 | Clock register write data |
| clk_reg_rdata_i | input | 8 | Clock register read data |

## Verification
A corrupted index register cannot be seen at once. It appears on the next data port access, where the read returns another location's byte or the clock strobe carries the wrong select. For this reason, every index write in the bench is followed by a data access. A wrong base or enable bit shows up in the same cycle as a dropped or unexpected io_hit_o. A lock bit that clears or sets wrongly shows up on the next data read as 0xFF, or as a stored value where 0xFF was expected. A write that should have been discarded is checked after reset by reading that location back.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  typedef enum logic [2:0] {
    CFG_ACT   = 3'd0,
    CFG_B0_HI = 3'd1,
    CFG_B0_LO = 3'd2,
    CFG_B1_HI = 3'd3,
    CFG_B1_LO = 3'd4,
    CFG_LOCK  = 3'd5
  } cfg_sel_e;

  localparam logic [7:0] B0_BASE_DEF = 8'h70;
  localparam logic [7:0] B1_BASE_DEF = 8'h74;
  localparam int         BASE_W      = 11;  // A11..A1
  localparam int         NBANKS      = 2;
endpackage

// File: rtl/cmos_cfg_regs.sv
module cmos_cfg_regs
  import cmos_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_wr_i,
  input  logic [2:0]                     cfg_sel_i,
  input  logic [7:0]                     cfg_wdata_i,
  output logic [7:0]                     cfg_rdata_o,
  output logic [NBANKS-1:0]              act_o,
  output logic [NBANKS-1:0][BASE_W-1:0]  base_o,
  output logic [NBANKS*NSEG-1:0]         lock_o
);
  logic [NBANKS-1:0]      act_q;
  logic [NBANKS-1:0][3:0] hi_q;
  logic [NBANKS-1:0][6:0] lo_q;
  logic [NBANKS*NSEG-1:0] lock_q;
  cfg_sel_e               sel;

  assign sel = cfg_sel_e'(cfg_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      hi_q   <= '0;
      lo_q[0] <= B0_BASE_DEF[7:1];
      lo_q[1] <= B1_BASE_DEF[7:1];
      lock_q <= '0;
    end else if (cfg_wr_i) begin
      unique case (sel)
        CFG_ACT:   act_q   <= cfg_wdata_i[NBANKS-1:0];
        CFG_B0_HI: hi_q[0] <= cfg_wdata_i[3:0];
        CFG_B0_LO: lo_q[0] <= cfg_wdata_i[7:1];
        CFG_B1_HI: hi_q[1] <= cfg_wdata_i[3:0];
        CFG_B1_LO: lo_q[1] <= cfg_wdata_i[7:1];
        CFG_LOCK:  lock_q  <= lock_q | cfg_wdata_i[NBANKS*NSEG-1:0];  // sticky
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata_o = 8'h00;
    unique case (sel)
      CFG_ACT:   cfg_rdata_o = 8'(act_q);
      CFG_B0_HI: cfg_rdata_o = {4'h0, hi_q[0]};
      CFG_B0_LO: cfg_rdata_o = {lo_q[0], 1'b0};
      CFG_B1_HI: cfg_rdata_o = {4'h0, hi_q[1]};
      CFG_B1_LO: cfg_rdata_o = {lo_q[1], 1'b0};
      CFG_LOCK:  cfg_rdata_o = 8'(lock_q);
      default:   cfg_rdata_o = 8'h00;
    endcase
  end

  assign act_o  = act_q;
  assign lock_o = lock_q;
  for (genvar b = 0; b < NBANKS; b++) begin : g_base
    assign base_o[b] = {hi_q[b], lo_q[b]};
  end
endmodule

// File: rtl/cmos_port_match.sv
module cmos_port_match
  import cmos_pkg::*;
(
  input  logic [11:0]       addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              en_i,
  output logic              idx_hit_o,
  output logic              dat_hit_o
);
  logic hit;
  assign hit       = en_i && (addr_i[11:1] == base_i);
  assign idx_hit_o = hit && !addr_i[0];
  assign dat_hit_o = hit &&  addr_i[0];
endmodule

// File: rtl/cmos_bank_store.sv
module cmos_bank_store #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/cmos_banked_port.sv
module cmos_banked_port
  import cmos_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_B   = 128,
  parameter int SEG_B    = 32,
  parameter int CLK_REGS = 15,
  localparam int IDX_W   = $clog2(BANK_B),
  localparam int NSEG    = BANK_B / SEG_B,
  localparam int SEG_W   = $clog2(NSEG),
  localparam int CLK_W   = $clog2(CLK_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_hit_o,
  output logic [CLK_W-1:0]  clk_reg_sel_o,
  output logic              clk_reg_rd_o,
  output logic              clk_reg_wr_o,
  output logic [7:0]        clk_reg_wdata_o,
  input  logic [7:0]        clk_reg_rdata_i
);
  localparam logic [IDX_W-1:0] CLK_LIM = IDX_W'(CLK_REGS);

  logic [NBANKS-1:0]             act;
  logic [NBANKS-1:0][BASE_W-1:0] base;
  logic [NBANKS*NSEG-1:0]        lock_bits;
  logic [NBANKS-1:0]             idx_hit, dat_hit, sel_b, locked, dat_wr, st_we;
  logic [NBANKS-1:0][IDX_W-1:0]  idx_q;
  logic [NBANKS-1:0][7:0]        st_rd;
  logic [7:0]                    shadow_q;
  logic                          is_clk;
  logic                          unused_addr_hi;

  assign unused_addr_hi = ^io_addr_i[ADDR_W-1:12];

  cmos_cfg_regs #(.NSEG(NSEG)) i_cfg (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_sel_i, .cfg_wdata_i, .cfg_rdata_o,
    .act_o(act), .base_o(base), .lock_o(lock_bits)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    cmos_port_match i_match (
      .addr_i(io_addr_i[11:0]), .base_i(base[b]), .en_i(act[b]),
      .idx_hit_o(idx_hit[b]), .dat_hit_o(dat_hit[b])
    );

    // lower bank index wins on overlapping bases
    if (b == 0) begin : g_pri
      assign sel_b[b] = idx_hit[b] | dat_hit[b];
    end else begin : g_sub
      assign sel_b[b] = (idx_hit[b] | dat_hit[b]) & ~(|sel_b[b-1:0]);
    end

    assign locked[b] = lock_bits[b*NSEG + int'(idx_q[b][IDX_W-1 -: SEG_W])];
    assign dat_wr[b] = io_wr_i && dat_hit[b] && sel_b[b] && !locked[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                idx_q[b] <= '0;
      else if (io_wr_i && idx_hit[b] && sel_b[b]) idx_q[b] <= io_wdata_i[IDX_W-1:0];
    end

    if (b == 0) begin : g_clkmap
      assign st_we[b] = dat_wr[b] && !is_clk;
    end else begin : g_ram
      assign st_we[b] = dat_wr[b];
    end

    cmos_bank_store #(.DEPTH(BANK_B), .W(8)) i_store (
      .clk_i, .we_i(st_we[b]), .addr_i(idx_q[b]),
      .wdata_i(io_wdata_i), .rdata_o(st_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              shadow_q <= '0;
    else if (io_wr_i && idx_hit[0] && sel_b[0]) shadow_q <= io_wdata_i;
  end

  assign is_clk          = idx_q[0] < CLK_LIM;
  assign clk_reg_sel_o   = idx_q[0][CLK_W-1:0];
  assign clk_reg_wdata_o = io_wdata_i;
  assign clk_reg_wr_o    = dat_wr[0] && is_clk;
  assign clk_reg_rd_o    = io_rd_i && dat_hit[0] && !locked[0] && is_clk;
  assign io_hit_o        = (io_rd_i || io_wr_i) && (|sel_b);

  always_comb begin
    io_rdata_o = 8'hFF;
    for (int b = 0; b < NBANKS; b++) begin
      if (io_rd_i && sel_b[b]) begin
        if (idx_hit[b])               io_rdata_o = (b == 0) ? shadow_q : 8'hFF;
        else if (locked[b])           io_rdata_o = 8'hFF;
        else if (b == 0 && is_clk)    io_rdata_o = clk_reg_rdata_i;
        else                          io_rdata_o = st_rd[b];
      end
    end
  end
endmodule

// File: rtl/cmos_banked_port_chk.sv
module cmos_banked_port_chk #(
  parameter int NLOCK = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       act,
  input logic [NLOCK-1:0] lock_bits,
  input logic             io_rd_i,
  input logic             io_wr_i,
  input logic             io_hit_o,
  input logic             clk_reg_wr_o,
  input logic             clk_reg_rd_o
);
  // R2
  act_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == 2'b00) |-> !io_hit_o);

  // R3
  hit_needs_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> (io_rd_i || io_wr_i));

  // R7
  clk_wr_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_reg_wr_o |-> (io_wr_i && io_hit_o && act[0]));

  // R7
  clk_rd_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_reg_rd_o |-> (io_rd_i && io_hit_o && act[0]));

  // R9
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

  // R9
  clk_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_reg_wr_o || clk_reg_rd_o) |-> !lock_bits[0]);
endmodule

bind cmos_banked_port cmos_banked_port_chk #(.NLOCK(NBANKS*NSEG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act(act), .lock_bits(lock_bits),
  .io_rd_i(io_rd_i), .io_wr_i(io_wr_i), .io_hit_o(io_hit_o),
  .clk_reg_wr_o(clk_reg_wr_o), .clk_reg_rd_o(clk_reg_rd_o)
);

// File: tb/test_cmos_banked_port.sv
module test_cmos_banked_port;
  typedef struct packed {
    logic [1:0]  op;   // 0 cfg wr, 1 cfg rd, 2 io wr, 3 io rd
    logic [15:0] a;
    logic [7:0]  d;
    logic        h;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0002, 8'h70, 1'b0, 4'd1},   // R1
    '{2'd1, 16'h0004, 8'h74, 1'b0, 4'd1},   // R1
    '{2'd1, 16'h0000, 8'h00, 1'b0, 4'd1},   // R1
    '{2'd2, 16'h0070, 8'h05, 1'b0, 4'd2},   // R2
    '{2'd3, 16'h0071, 8'hFF, 1'b0, 4'd2},   // R2
    '{2'd0, 16'h0000, 8'h01, 1'b0, 4'd2},   // R2
    '{2'd2, 16'h0070, 8'h85, 1'b1, 4'd5},   // R5
    '{2'd3, 16'h0070, 8'h85, 1'b1, 4'd6},   // R6
    '{2'd2, 16'h0070, 8'hA0, 1'b1, 4'd5},   // R5
    '{2'd2, 16'h0071, 8'h3C, 1'b1, 4'd5},   // R5
    '{2'd3, 16'h0071, 8'h3C, 1'b1, 4'd5},   // R5
    '{2'd3, 16'h0074, 8'hFF, 1'b0, 4'd2},   // R2
    '{2'd3, 16'hF071, 8'h3C, 1'b1, 4'd3},   // R3
    '{2'd3, 16'h0171, 8'hFF, 1'b0, 4'd3},   // R3
    '{2'd0, 16'h0000, 8'h03, 1'b0, 4'd2},   // R2
    '{2'd2, 16'h0074, 8'h20, 1'b1, 4'd5},   // R5
    '{2'd2, 16'h0075, 8'h5A, 1'b1, 4'd8},   // R8
    '{2'd3, 16'h0075, 8'h5A, 1'b1, 4'd8},   // R8
    '{2'd3, 16'h0071, 8'h3C, 1'b1, 4'd8},   // R8
    '{2'd3, 16'h0074, 8'hFF, 1'b1, 4'd6},   // R6
    '{2'd3, 16'h0070, 8'hA0, 1'b1, 4'd6},   // R6
    '{2'd0, 16'h0003, 8'hF2, 1'b0, 4'd4},   // R4
    '{2'd1, 16'h0003, 8'h02, 1'b0, 4'd4},   // R4
    '{2'd0, 16'h0004, 8'h41, 1'b0, 4'd4},   // R4
    '{2'd1, 16'h0004, 8'h40, 1'b0, 4'd4},   // R4
    '{2'd3, 16'h0075, 8'hFF, 1'b0, 4'd3},   // R3
    '{2'd3, 16'h0241, 8'h5A, 1'b1, 4'd3},   // R3
    '{2'd3, 16'h0240, 8'hFF, 1'b1, 4'd3},   // R3
    '{2'd0, 16'h0003, 8'h00, 1'b0, 4'd10},  // R10
    '{2'd0, 16'h0004, 8'h70, 1'b0, 4'd10},  // R10
    '{2'd3, 16'h0071, 8'h3C, 1'b1, 4'd10},  // R10
    '{2'd0, 16'h0004, 8'h74, 1'b0, 4'd10},  // R10
    '{2'd2, 16'h0070, 8'h07, 1'b1, 4'd7},   // R7
    '{2'd3, 16'h0071, 8'hA7, 1'b1, 4'd7},   // R7
    '{2'd2, 16'h0070, 8'h0E, 1'b1, 4'd7},   // R7
    '{2'd3, 16'h0071, 8'hAE, 1'b1, 4'd7},   // R7
    '{2'd2, 16'h0070, 8'h0F, 1'b1, 4'd7},   // R7
    '{2'd2, 16'h0071, 8'h11, 1'b1, 4'd7},   // R7
    '{2'd3, 16'h0071, 8'h11, 1'b1, 4'd7},   // R7
    '{2'd0, 16'h0005, 8'h02, 1'b0, 4'd9},   // R9
    '{2'd2, 16'h0070, 8'h20, 1'b1, 4'd9},   // R9
    '{2'd3, 16'h0071, 8'hFF, 1'b1, 4'd9},   // R9
    '{2'd2, 16'h0071, 8'h77, 1'b1, 4'd9},   // R9
    '{2'd0, 16'h0005, 8'h00, 1'b0, 4'd9},   // R9
    '{2'd1, 16'h0005, 8'h02, 1'b0, 4'd9},   // R9
    '{2'd3, 16'h0071, 8'hFF, 1'b1, 4'd9},   // R9
    '{2'd3, 16'h0075, 8'h5A, 1'b1, 4'd9},   // R9
    '{2'd2, 16'h0070, 8'h0F, 1'b1, 4'd9},   // R9
    '{2'd3, 16'h0071, 8'h11, 1'b1, 4'd9}    // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        io_hit;
  logic [3:0]  ck_sel;
  logic        ck_rd, ck_wr;
  logic [7:0]  ck_wdata, ck_rdata;

  int n_chk = 0, n_fail = 0;
  logic       s_hit, s_cwr, s_crd;
  logic [7:0] s_rd, s_cfg, s_cwd;
  logic [3:0] s_csel;

  always #5 clk = ~clk;
  assign ck_rdata = {4'hA, ck_sel};

  cmos_banked_port i_cmos_banked_port (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_hit_o(io_hit),
    .clk_reg_sel_o(ck_sel), .clk_reg_rd_o(ck_rd), .clk_reg_wr_o(ck_wr),
    .clk_reg_wdata_o(ck_wdata), .clk_reg_rdata_i(ck_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] s);
    @(negedge clk);
    cfg_sel = s;
    #2 s_cfg = cfg_rdata;
  endtask

  task automatic io_op(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = !w; io_wdata = d;
    #2;
    s_hit = io_hit; s_rd = io_rdata; s_cwr = ck_wr; s_crd = ck_rd;
    s_csel = ck_sel; s_cwd = ck_wdata;
    @(posedge clk); #1;
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2 check("R1 no hit in reset state", io_hit, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].r, i);
      case (VEC[i].op)
        2'd0: cfg_write(VEC[i].a[2:0], VEC[i].d);
        2'd1: begin cfg_read(VEC[i].a[2:0]); check(tag, s_cfg, VEC[i].d); end
        2'd2: begin io_op(1'b1, VEC[i].a, VEC[i].d); check(tag, s_hit, VEC[i].h); end
        default: begin
          io_op(1'b0, VEC[i].a, 8'h00);
          check({tag, " hit"}, s_hit, VEC[i].h);
          check({tag, " data"}, s_rd, VEC[i].d);
        end
      endcase
    end

    // R7 clock strobes, range 0 still unlocked
    io_op(1'b1, 16'h0070, 8'h03);
    io_op(1'b1, 16'h0071, 8'h66);
    check("R7 clk wr strobe", s_cwr, 1);
    check("R7 clk sel", s_csel, 4'h3);
    check("R7 clk wdata", s_cwd, 8'h66);
    io_op(1'b0, 16'h0071, 8'h00);
    check("R7 clk rd strobe", s_crd, 1);
    check("R7 clk rdata", s_rd, 8'hA3);

    // R9 lock range 0 blocks clock access
    cfg_write(3'd5, 8'h01);
    io_op(1'b1, 16'h0071, 8'h55);
    check("R9 clk wr blocked", s_cwr, 0);
    io_op(1'b0, 16'h0071, 8'h00);
    check("R9 clk rd blocked", s_crd, 0);
    check("R9 locked read", s_rd, 8'hFF);

    // R1 / R9 reset clears locks; earlier locked write was discarded
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_read(3'd5); check("R9 lock cleared by reset", s_cfg, 0);
    cfg_read(3'd0); check("R1 enable after reset", s_cfg, 0);
    cfg_read(3'd2); check("R1 bank0 base after reset", s_cfg, 8'h70);
    io_op(1'b0, 16'h0071, 8'h00);
    check("R1 no hit after reset", s_hit, 0);
    cfg_write(3'd0, 8'h01);
    io_op(1'b1, 16'h0070, 8'h20);
    io_op(1'b0, 16'h0071, 8'h00);
    check("R9 locked write discarded", s_rd, 8'h3C);

    summary();
  end
endmodule